// File: doc/BRIEF.md
# Coalesced Triangular Loop Sequencer

This block flattens a two-level triangular index space into one stream that feeds a pipelined datapath with an initiation interval of one. For a run-time size N it emits every pair (i, j) with 0 ≤ i < N and 0 ≤ j < N−i. Pairs come out in lexicographic order, one slot per accepted cycle. The datapath has a read-to-write latency Δ, and a value written at (i, j) is read back at (i+1, j). Rows that are too short to cover that latency are followed by wait-state slots ("bubbles"), so that each consumer issues at least Δ slots after its producer.

Two padding policies are available. The minimal policy appends exactly enough bubbles to meet the latency. The conservative policy appends Δ−1 bubbles after every row that needs any padding. Size, latency and policy are captured when a run starts. The stream is throttled by a ready input, and a done pulse marks the end of the run.

Top module: `tri_loop_seq`

## Requirements
- R1: While reset is asserted and after it is released, valid_o and done_o are low until a start is accepted.
- R2: Real (non-bubble) slots carry every pair (i, j) with 0 ≤ i < N, 0 ≤ j < N−i exactly once, in lexicographic order, on row_o and col_o.
- R3: While slots remain, valid_o is high in every cycle, starting the cycle after start_i is taken. With ready_i high, one slot is issued per cycle with no gaps.
- R4: With pad_all_i low, row i < N−1 is followed by max(0, Δ−(N−i)) bubble slots (valid_o=1, bubble_o=1), placed right after that row's last pair and before row i+1. Row N−1 gets none.
- R5: With pad_all_i high, each row i < N−1 with Δ > N−i is followed by Δ−1 bubbles, and every other row by none.
- R6: last_o is high only on the real slot (N−1, 0).
- R7: When valid_o is high and ready_i is low, the next cycle shows the same slot: valid_o, bubble_o, last_o, row_o and col_o are unchanged.
- R8: done_o pulses for exactly one cycle, in the cycle after the final slot is accepted. For N=0 it pulses in the cycle after start, and no slot is issued.
- R9: start_i, size_i, lat_i and pad_all_i have no effect while a run is in progress. The run's stream is fixed by the values present when the start was taken.
- R10: In both modes, for every pair with a consumer, the slot index of (i+1, j) minus that of (i, j) is at least Δ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (taken only when idle) |
| size_i | input | IDX_W | Domain size N |
| lat_i | input | LAT_W | Datapath latency Δ |
| pad_all_i | input | 1 | 1 selects conservative padding |
| ready_i | input | 1 | Consumer accepts the current slot |
| valid_o | output | 1 | A slot is presented |
| bubble_o | output | 1 | Current slot is a wait state |
| last_o | output | 1 | Current slot is the final pair |
| row_o | output | IDX_W | Outer index i |
| col_o | output | IDX_W | Inner index j |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
The case hardest to reach is a bubble slot held under backpressure at the seam between a padded row and the next row. It occurs only when Δ exceeds the remaining row length and ready_i falls in that exact cycle. The bench sweeps every size from 0 to 12, every latency from 1 to 8 and both policies. It uses a periodic ready pattern on half of the runs, so that stalls land on row ends, on bubbles and on the final pair. Separate runs pulse start_i with a different size mid-run, and the inputs are scrambled after every start, to show that a run is sealed against them.

// File: rtl/tri_seq_pkg.sv
package tri_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_PAD  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/tri_pad_calc.sv
// Wait-state count owed after the current row.
module tri_pad_calc #(
  parameter int IDX_W = 4,
  parameter int LAT_W = 4
) (
  input  logic [IDX_W-1:0] row_i,
  input  logic [IDX_W-1:0] size_i,
  input  logic [LAT_W-1:0] lat_i,
  input  logic             pad_all_i,
  output logic [LAT_W-1:0] pad_o
);
  localparam int CW = ((IDX_W > LAT_W) ? IDX_W : LAT_W) + 1;

  logic [CW-1:0] rem_w, lat_w, gap_w;
  logic          short_w, tail_w;

  assign rem_w   = CW'(size_i) - CW'(row_i);
  assign lat_w   = CW'(lat_i);
  assign gap_w   = lat_w - rem_w;
  assign short_w = lat_w > rem_w;
  assign tail_w  = (CW'(row_i) + CW'(1)) == CW'(size_i);

  always_comb begin
    if (tail_w || !short_w) pad_o = '0;
    else if (pad_all_i)     pad_o = lat_i - LAT_W'(1);
    else                    pad_o = LAT_W'(gap_w);
  end
endmodule

// File: rtl/tri_walk_ctrl.sv
module tri_walk_ctrl
  import tri_seq_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int LAT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] size_i,
  input  logic [LAT_W-1:0] lat_i,
  input  logic             pad_all_i,
  input  logic             ready_i,
  input  logic [LAT_W-1:0] pad_cnt_i,
  output logic [IDX_W-1:0] row_o,
  output logic [IDX_W-1:0] col_o,
  output logic [IDX_W-1:0] n_o,
  output logic [LAT_W-1:0] lat_o,
  output logic             mode_o,
  output logic             valid_o,
  output logic             bubble_o,
  output logic             last_o,
  output logic             done_o
);
  localparam int SW = IDX_W + 1;

  seq_state_e       state_q;
  logic [IDX_W-1:0] row_q, col_q, n_q;
  logic [LAT_W-1:0] lat_q, pad_left_q;
  logic             mode_q, done_q;
  logic             fire, row_end, final_row;

  assign fire      = valid_o & ready_i;
  assign row_end   = (SW'(col_q) + SW'(row_q)) == (SW'(n_q) - SW'(1));
  assign final_row = row_q == (n_q - IDX_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      row_q      <= '0;
      col_q      <= '0;
      n_q        <= '0;
      lat_q      <= '0;
      pad_left_q <= '0;
      mode_q     <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (size_i == '0) begin
              done_q <= 1'b1;
            end else begin
              n_q     <= size_i;
              lat_q   <= lat_i;
              mode_q  <= pad_all_i;
              row_q   <= '0;
              col_q   <= '0;
              state_q <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (fire) begin
            if (row_end) begin
              if (final_row) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end else if (pad_cnt_i != '0) begin
                pad_left_q <= pad_cnt_i;
                state_q    <= ST_PAD;
              end else begin
                row_q <= row_q + IDX_W'(1);
                col_q <= '0;
              end
            end else begin
              col_q <= col_q + IDX_W'(1);
            end
          end
        end
        ST_PAD: begin
          if (fire) begin
            pad_left_q <= pad_left_q - LAT_W'(1);
            if (pad_left_q == LAT_W'(1)) begin
              row_q   <= row_q + IDX_W'(1);
              col_q   <= '0;
              state_q <= ST_RUN;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign row_o    = row_q;
  assign col_o    = col_q;
  assign n_o      = n_q;
  assign lat_o    = lat_q;
  assign mode_o   = mode_q;
  assign valid_o  = state_q != ST_IDLE;
  assign bubble_o = state_q == ST_PAD;
  assign last_o   = (state_q == ST_RUN) && final_row;
  assign done_o   = done_q;

  assert_pad_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAD) |-> (pad_left_q != '0) && (pad_left_q < lat_q));
  assert_col_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |-> ((SW'(col_q) + SW'(row_q)) < SW'(n_q)));
  assert_size_sealed_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o)) |-> $stable(n_q) && $stable(lat_q) && $stable(mode_q));
endmodule

// File: rtl/tri_loop_seq.sv
module tri_loop_seq #(
  parameter int IDX_W = 4,
  parameter int LAT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] size_i,
  input  logic [LAT_W-1:0] lat_i,
  input  logic             pad_all_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic             bubble_o,
  output logic             last_o,
  output logic [IDX_W-1:0] row_o,
  output logic [IDX_W-1:0] col_o,
  output logic             done_o
);
  logic [IDX_W-1:0] row_w, n_w;
  logic [LAT_W-1:0] lat_w, pad_w;
  logic             mode_w;

  tri_pad_calc #(.IDX_W(IDX_W), .LAT_W(LAT_W)) u_pad (
    .row_i(row_w), .size_i(n_w), .lat_i(lat_w), .pad_all_i(mode_w), .pad_o(pad_w)
  );

  tri_walk_ctrl #(.IDX_W(IDX_W), .LAT_W(LAT_W)) u_walk (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .size_i(size_i),
    .lat_i(lat_i), .pad_all_i(pad_all_i), .ready_i(ready_i), .pad_cnt_i(pad_w),
    .row_o(row_w), .col_o(col_o), .n_o(n_w), .lat_o(lat_w), .mode_o(mode_w),
    .valid_o(valid_o), .bubble_o(bubble_o), .last_o(last_o), .done_o(done_o)
  );

  assign row_o = row_w;

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> valid_o && $stable(bubble_o) && $stable(last_o)
                              && $stable(row_o) && $stable(col_o));
  assert_last_real_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o && !bubble_o && (col_o == '0));
  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o);
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/tb_tri_loop_seq.sv
module tb_tri_loop_seq;
  localparam int IW = 4;
  localparam int LW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, start, pad_all, ready;
  logic [IW-1:0] size;
  logic [LW-1:0] lat;
  logic          valid, bubble, last, done;
  logic [IW-1:0] row, col;

  tri_loop_seq #(.IDX_W(IW), .LAT_W(LW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .size_i(size), .lat_i(lat),
    .pad_all_i(pad_all), .ready_i(ready), .valid_o(valid), .bubble_o(bubble),
    .last_o(last), .row_o(row), .col_o(col), .done_o(done)
  );

  int vectors = 0;
  int fails   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_case(input int n, input int d, input bit mode,
                          input bit bp, input bit poke);
    int eb[$], ei[$], ej[$], el[$];
    int pos[16][16];
    int slot = 0;
    int cyc = 0;
    bit stalled = 0;
    int pb = 0, pl = 0, pr = 0, pc = 0;
    string preq = mode ? "R5" : "R4";
    for (int i = 0; i < n; i++) begin
      for (int j = 0; j < n - i; j++) begin
        eb.push_back(0); ei.push_back(i); ej.push_back(j);
        el.push_back(i == n - 1 && j == 0);
      end
      if (i < n - 1 && d - (n - i) > 0) begin
        int pads = mode ? d - 1 : d - (n - i);
        for (int k = 0; k < pads; k++) begin
          eb.push_back(1); ei.push_back(0); ej.push_back(0); el.push_back(0);
        end
      end
    end
    @(negedge clk);
    start = 1; size = IW'(n); lat = LW'(d); pad_all = mode; ready = 0;
    @(negedge clk);
    start = 0; size = IW'(n ^ 6); lat = LW'(~d); pad_all = ~mode;  // R9: scrambled after start
    if (n == 0) begin
      chk(done == 1, "R8", "done after empty start", done, 1);
      chk(valid == 0, "R8", "no slot for N=0", valid, 0);
      @(negedge clk);
      chk(done == 0, "R8", "done single pulse", done, 0);
      return;
    end
    while (eb.size() > 0 && cyc < 3000) begin
      bit r;
      chk(valid == 1, "R3", "valid while slots remain", valid, 1);
      chk(done == 0, "R8", "no done mid-run", done, 0);
      if (stalled) begin
        chk(bubble == pb && last == pl, "R7", "flags held", {bubble, last}, pb * 2 + pl);
        chk(pb == 1 || (row == pr && col == pc), "R7", "index held", row * 16 + col, pr * 16 + pc);
      end
      r = bp ? ((cyc * 5 + n) % 3 != 0) : 1'b1;
      ready = r;
      if (r && valid) begin
        chk(bubble == eb[0], preq, "bubble flag", bubble, eb[0]);
        if (eb[0] == 0 && bubble == 0) begin
          chk(row == ei[0] && col == ej[0], "R2", "index pair", row * 16 + col, ei[0] * 16 + ej[0]);
          chk(last == el[0], "R6", "last flag", last, el[0]);
          pos[ei[0]][ej[0]] = slot;
        end
        void'(eb.pop_front()); void'(ei.pop_front());
        void'(ej.pop_front()); void'(el.pop_front());
        slot++;
      end
      start = (poke && cyc == 4);
      if (poke && cyc == 4) size = 2;
      pb = bubble; pl = last; pr = row; pc = col;
      stalled = valid && !r;
      cyc++;
      @(negedge clk);
    end
    start = 0;
    chk(cyc < 3000, "R3", "case finished", cyc, 0);
    chk(done == 1, "R8", "done after final slot", done, 1);
    chk(valid == 0, "R8", "idle after final slot", valid, 0);
    ready = 0;
    @(negedge clk);
    chk(done == 0, "R8", "done single pulse", done, 0);
    for (int i = 0; i < n - 1; i++)
      for (int j = 0; j < n - i - 1; j++)
        chk(pos[i + 1][j] - pos[i][j] >= d, "R10", "dependence distance",
            pos[i + 1][j] - pos[i][j], d);
  endtask

  initial begin
    #(8 * 190000);
    fails++; vectors++;
    $display("FAIL R3 watchdog expired: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 0; start = 0; size = '0; lat = '0; pad_all = 0; ready = 0;
    repeat (3) @(negedge clk);
    chk(valid == 0 && done == 0, "R1", "outputs in reset", {valid, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(valid == 0 && done == 0, "R1", "outputs after reset", {valid, done}, 0);
    for (int n = 0; n <= 12; n++)
      for (int d = 1; d <= 8; d++)
        for (int m = 0; m < 2; m++)
          run_case(n, d, m[0], 1'((n + d + m) % 2), n >= 5 && d == 3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule